// File: doc/BRIEF.md
# Log-Domain Galois Field Multiplier

This block multiplies two elements of the binary extension field GF(2^M) by moving to the log domain. Each nonzero operand is replaced by its discrete logarithm with respect to a primitive element. The two logarithms are summed modulo 2^M-1 by an adder whose carry out is fed back into its least significant bit. The sum is then mapped back through an antilog table. Both tables are computed at elaboration time from the primitive polynomial parameter, so no memory image file is involved.

The block is a three-stage pipeline. It takes one operand pair per clock, with a valid flag, and returns the product with a matching valid flag a fixed number of cycles later. A zero operand has no logarithm, so a flag carried beside the data forces the product to zero. The wrapped log sum can land on 2^M-1 instead of 0. It is left unreduced, because the antilog table holds 1 at both indices.

A design that adds a field element between two products must take the value out of the log domain first, so this block is meant to be used as a single multiply step.

Top module: `gflm_top`

## Requirements
- R1: For op_a and op_b in GF(2^M), with bit i holding the coefficient of x^i and reduction by POLY (default M = 10, POLY = 11'h409, that is x^10+x^3+1), product equals the field product op_a·op_b.
- R2: The product and out_vld appear at the third rising clock edge, counting the edge that samples in_vld and the operands as the first. out_vld is high at that point exactly when in_vld was high at the sampling edge.
- R3: A new operand pair is accepted on every cycle. Back-to-back valid inputs give back-to-back results in the same order.
- R4: If op_a or op_b is zero, product is zero.
- R5: When the two logarithms sum to exactly 2^M-1, for example α^k · α^(2^M-1-k), the product is 1.
- R6: When the logarithm sum is 2^M-1 or more, it wraps modulo 2^M-1. For example, α^1000 · α^500 gives α^477 for M = 10.
- R7: Synchronous active-high rst clears every pipeline stage. out_vld is low on the edge after rst, and nothing accepted before rst produces a result.
- R8: Multiplying by the element 1 returns the other operand unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand pair is valid this cycle |
| op_a | input | M | First field element |
| op_b | input | M | Second field element |
| out_vld | output | 1 | product is valid this cycle |
| product | output | M | Field product op_a·op_b |

## Verification
The patterns used are:
- Every element multiplied by a handful of fixed elements, which checks the log and antilog tables entry by entry against a shift-and-XOR reference.
- Inverse pairs, whose logs sum to exactly 2^M-1. These reach the redundant index and separate it from an ordinary wrap.
- Large-exponent pairs, which force the end-around carry.
- Zero and unity operands, which check the bypass and the identity.
- A long random stream with continuous valid, and a second with valid toggled at random, which check ordering and the exact latency.
- A reset issued with inputs in flight, which must yield no result.

// File: rtl/gflm_pkg.sv
package gflm_pkg;

    localparam int MAXW = 16;

    // Tag that travels beside the data through every stage
    typedef struct packed {
        logic vld;
        logic zero;
    } gflm_tag_t;

    // Multiply a field element by x and reduce by the polynomial of degree m
    function automatic logic [MAXW-1:0] gf_xtime(
        input logic [MAXW-1:0] v,
        input logic [MAXW:0]   poly,
        input int              m
    );
        logic [MAXW:0] s;
        s = {v, 1'b0};
        if (s[m]) s = s ^ poly;
        return s[MAXW-1:0];
    endfunction

endpackage

// File: rtl/gflm_log_stage.sv
module gflm_log_stage
    import gflm_pkg::*;
#(
    parameter int         M    = 10,
    parameter logic [M:0] POLY = 11'h409
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            vld_i,
    input  logic [M-1:0]    a_i,
    input  logic [M-1:0]    b_i,
    output gflm_tag_t       tag_o,
    output logic [M-1:0]    la_o,
    output logic [M-1:0]    lb_o
);
    localparam int N = 1 << M;

    typedef logic [M-1:0] tbl_t [0:N-1];

    function automatic tbl_t build_log();
        tbl_t        t;
        logic [M-1:0] e;
        for (int i = 0; i < N; i++) t[i] = '0;
        e = M'(1);
        for (int k = 0; k < N - 1; k++) begin
            t[e] = M'(k);
            e    = M'(gf_xtime(MAXW'(e), (MAXW+1)'(POLY), M));
        end
        return t;
    endfunction

    localparam tbl_t LOG_TBL = build_log();

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_o <= '0;
            la_o  <= '0;
            lb_o  <= '0;
        end else begin
            tag_o.vld  <= vld_i;
            tag_o.zero <= (a_i == '0) || (b_i == '0);
            la_o       <= LOG_TBL[a_i];
            lb_o       <= LOG_TBL[b_i];
        end
    end

    // R1: a nonzero operand never has a logarithm of 2^M-1
    log_range_chk: assert property (@(posedge clk) disable iff (rst)
        (tag_o.vld && !tag_o.zero) |-> (la_o != M'(N-1)) && (lb_o != M'(N-1)));

endmodule

// File: rtl/gflm_eac_add.sv
module gflm_eac_add
    import gflm_pkg::*;
#(
    parameter int M = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  gflm_tag_t    tag_i,
    input  logic [M-1:0] la_i,
    input  logic [M-1:0] lb_i,
    output gflm_tag_t    tag_o,
    output logic [M-1:0] sum_o
);
    localparam int N = 1 << M;

    logic [M:0]   raw;
    logic [M-1:0] wrapped;

    always_comb begin
        raw     = {1'b0, la_i} + {1'b0, lb_i};
        wrapped = raw[M-1:0] + M'(raw[M]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_o <= '0;
            sum_o <= '0;
        end else begin
            tag_o <= tag_i;
            sum_o <= wrapped;
        end
    end

    // R6
    eac_modulo_chk: assert property (@(posedge clk) disable iff (rst)
        (tag_o.vld && !tag_o.zero) |->
            (int'(sum_o) % (N-1)) == ((int'($past(la_i)) + int'($past(lb_i))) % (N-1)));

    // R5
    eac_redundant_chk: assert property (@(posedge clk) disable iff (rst)
        (tag_o.vld && !tag_o.zero && sum_o == M'(N-1)) |->
            (int'($past(la_i)) + int'($past(lb_i))) == N-1);

endmodule

// File: rtl/gflm_alog_stage.sv
module gflm_alog_stage
    import gflm_pkg::*;
#(
    parameter int         M    = 10,
    parameter logic [M:0] POLY = 11'h409
) (
    input  logic         clk,
    input  logic         rst,
    input  gflm_tag_t    tag_i,
    input  logic [M-1:0] sum_i,
    output logic         vld_o,
    output logic [M-1:0] prod_o
);
    localparam int N = 1 << M;

    typedef logic [M-1:0] tbl_t [0:N-1];

    function automatic tbl_t build_alog();
        tbl_t         t;
        logic [M-1:0] e;
        e = M'(1);
        for (int k = 0; k < N - 1; k++) begin
            t[k] = e;
            e    = M'(gf_xtime(MAXW'(e), (MAXW+1)'(POLY), M));
        end
        t[N-1] = M'(1);
        return t;
    endfunction

    localparam tbl_t ALOG_TBL = build_alog();

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            prod_o <= '0;
        end else begin
            vld_o  <= tag_i.vld;
            prod_o <= tag_i.zero ? '0 : ALOG_TBL[sum_i];
        end
    end

    // R1: the product of two nonzero elements is nonzero
    nonzero_prod_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(tag_i.vld) && !$past(tag_i.zero)) |-> (vld_o && prod_o != '0));

endmodule

// File: rtl/gflm_top.sv
module gflm_top
    import gflm_pkg::*;
#(
    parameter int         M    = 10,
    parameter logic [M:0] POLY = 11'h409
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [M-1:0] op_a,
    input  logic [M-1:0] op_b,
    output logic         out_vld,
    output logic [M-1:0] product
);
    gflm_tag_t    tag_s1, tag_s2;
    logic [M-1:0] la_s1, lb_s1, sum_s2;

    gflm_log_stage #(.M(M), .POLY(POLY)) u_log (
        .clk(clk), .rst(rst), .vld_i(in_vld), .a_i(op_a), .b_i(op_b),
        .tag_o(tag_s1), .la_o(la_s1), .lb_o(lb_s1)
    );

    gflm_eac_add #(.M(M)) u_add (
        .clk(clk), .rst(rst), .tag_i(tag_s1), .la_i(la_s1), .lb_i(lb_s1),
        .tag_o(tag_s2), .sum_o(sum_s2)
    );

    gflm_alog_stage #(.M(M), .POLY(POLY)) u_alog (
        .clk(clk), .rst(rst), .tag_i(tag_s2), .sum_i(sum_s2),
        .vld_o(out_vld), .prod_o(product)
    );

    // Edges since reset, saturating, so $past never reaches before reset
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_vld == $past(in_vld, 3)));

    // R4
    zero_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && (op_a == '0 || op_b == '0)) |=> ##2 (out_vld && product == '0));

    // R7
    reset_flush_chk: assert property (@(posedge clk)
        rst |=> !out_vld);

endmodule

// File: tb/test_gflm_top.sv
module test_gflm_top;
    localparam int         M    = 10;
    localparam int         N    = 1 << M;
    localparam logic [M:0] POLY = 11'h409;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_vld = 1'b0;
    logic [M-1:0] op_a = '0;
    logic [M-1:0] op_b = '0;
    logic         out_vld;
    logic [M-1:0] product;

    gflm_top #(.M(M), .POLY(POLY)) i_gflm_top (
        .clk(clk), .rst(rst), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
        .out_vld(out_vld), .product(product)
    );

    always #2 clk = ~clk;   // 250 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        logic [M-1:0] exp;
        int           due;
        string        req;
    } item_t;
    item_t sbq[$];

    logic [M-1:0] apow [0:N-2];

    function automatic logic [M-1:0] ref_mul(logic [M-1:0] a, logic [M-1:0] b);
        logic [2*M-1:0] p;
        p = '0;
        for (int i = 0; i < M; i++)
            if (b[i]) p = p ^ ((2*M)'(a) << i);
        for (int i = 2*M-1; i >= M; i--)
            if (p[i]) p = p ^ ((2*M)'(POLY) << (i - M));
        return p[M-1:0];
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: one pair per call, expectation pushed to the scoreboard
    task automatic send(logic [M-1:0] a, logic [M-1:0] b, logic [M-1:0] exp, string req);
        @(negedge clk);
        in_vld = 1'b1;
        op_a   = a;
        op_b   = b;
        sbq.push_back('{exp: exp, due: cyc + 3, req: req});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
        end
    endtask

    // Monitor: compares as results come out
    always @(negedge clk) begin
        if (!rst) begin
            if (out_vld) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R2", "unexpected out_vld", 1, 0);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    check(cyc == it.due, "R2", "latency cycle", cyc, it.due);
                    check(product == it.exp, it.req, "product", int'(product), int'(it.exp));
                end
            end else if (sbq.size() != 0 && sbq[0].due <= cyc) begin
                check(1'b0, "R2", "missing out_vld", 0, 1);
                void'(sbq.pop_front());
            end
        end
    end

    initial begin
        apow[0] = M'(1);
        for (int k = 1; k < N-1; k++) apow[k] = ref_mul(apow[k-1], M'(2));

        // R7: reset state
        repeat (3) @(negedge clk);
        check(out_vld == 1'b0, "R7", "out_vld in reset", int'(out_vld), 0);
        rst = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(out_vld == 1'b0, "R7", "out_vld after reset", int'(out_vld), 0);
        end

        // R8: identity
        for (int i = 0; i < 8; i++) begin
            logic [M-1:0] a;
            a = M'($urandom_range(1, N-1));
            send(a, M'(1), a, "R8");
            send(M'(1), a, a, "R8");
        end
        idle(4);

        // R4: zero operands
        send('0, M'(5), '0, "R4");
        send(M'(777), '0, '0, "R4");
        send('0, '0, '0, "R4");
        send(M'(N-1), '0, '0, "R4");
        idle(4);

        // R5: logs summing to exactly 2^M-1
        for (int k = 1; k < N-1; k += 97)
            send(apow[k], apow[N-1-k], M'(1), "R5");
        idle(4);

        // R6: wrapped log sum
        send(apow[1000], apow[500], apow[477], "R6");
        send(apow[N-2], apow[N-2], apow[N-3], "R6");
        send(apow[600], apow[700], ref_mul(apow[600], apow[700]), "R6");
        idle(4);

        // R1: every element against a few fixed elements, continuous stream
        for (int b = 0; b < 4; b++) begin
            logic [M-1:0] bv;
            bv = (b == 0) ? M'(2) : (b == 1) ? M'(N-1) : (b == 2) ? M'(291) : M'(1000);
            for (int a = 0; a < N; a++)
                send(M'(a), bv, ref_mul(M'(a), bv), "R1");
        end
        idle(4);

        // R3: random back-to-back stream
        for (int i = 0; i < 300; i++) begin
            logic [M-1:0] a, b;
            a = M'($urandom);
            b = M'($urandom);
            send(a, b, ref_mul(a, b), "R3");
        end

        // R2: random valid gaps
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 1) == 1) begin
                logic [M-1:0] a, b;
                a = M'($urandom);
                b = M'($urandom);
                send(a, b, ref_mul(a, b), "R2");
            end else begin
                idle(1);
            end
        end
        idle(6);
        check(sbq.size() == 0, "R2", "results left pending", sbq.size(), 0);

        // R7: reset with inputs in flight, nothing must emerge
        @(negedge clk);
        in_vld = 1'b1; op_a = M'(3); op_b = M'(9);
        @(negedge clk);
        rst = 1'b1; in_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        repeat (5) begin
            @(negedge clk);
            check(out_vld == 1'b0, "R7", "out_vld after flush", int'(out_vld), 0);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule